// File: doc/BRIEF.md
# Memory-device boundary-scan test port

This block is the test access port of a synchronous memory device. A sixteen-state controller steps on the rising edge of TCK under TMS. It picks which scan register sits between TDI and TDO: a 3-bit instruction register, a 1-bit bypass register, a 32-bit identification register, or a boundary-scan register. The boundary-scan register is built from cells on the device pins.

The instruction set has three working codes:
- One captures the pins into the boundary register and drives its update stage onto the pins.
- One reads out the identification word.
- One captures the pins and also forces every memory output driver to high impedance.

The reserved code, and every code that has no meaning, falls back to the bypass register with the high-impedance force off. A parameter selects the memory organisation. That choice sets the width/density field of the identification word and the length of the boundary register. The pin side of the boundary cells is brought out as parallel buses.

Top module: `scan_port`

## Requirements
- R1: The controller enters Test-Logic-Reset when TRST_N is low (asynchronously) or after five rising TCK edges with TMS high. In that state the instruction becomes IDCODE (001), so `hiz_force` is 0 and `drive_pins` is 0.
- R2: The instruction register is 3 bits. In Capture-IR its shift stage loads 001, which shifts out in the order 1, 0, 0. A new code takes effect when the controller passes through Update-IR.
- R3: Code 001 selects a 32-bit identification register. Capture-DR loads it with a word that reads from MSB to LSB as follows: revision 000, depth 01011, architecture 000000, width/density code, vendor 00000110100, and a fixed 1 in bit 0.
- R4: Code 000 selects the boundary register. Capture-DR loads `pin_in`, Update-DR copies the shifted contents to `pin_out`, and `drive_pins` is 1 while this code is current.
- R5: Code 010 selects the boundary register, which captures `pin_in`. `hiz_force` is 1 while this code is current and 0 under every other code.
- R6: Code 011 and codes 100 to 111 select the 1-bit bypass register, which captures 0. Under these codes `hiz_force` stays 0.
- R7: Every register shifts LSB first, with TDI entering at the MSB. TDO changes only on the falling edge of TCK.
- R8: `tdo_en` is 1 only while the controller is in Shift-DR or Shift-IR.
- R9: Parameter ORG picks the organisation. ORG 0 gives width code 100111 and an 89-bit boundary register. ORG 1 gives 010111 and 89 bits. ORG 2 gives 110111 and 138 bits.
- R10: `pin_out` changes only on Update-DR under a boundary-register code. Data scans under other codes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on the falling edge |
| tdo_en | output | 1 | TDO driver enable |
| pin_in | input | BSR_LEN | Values sampled from the device pins |
| pin_out | output | BSR_LEN | Boundary update stage toward the pins |
| drive_pins | output | 1 | Boundary update stage owns the pins |
| hiz_force | output | 1 | Forces memory output drivers to high impedance |

## Verification
The hardest case is showing that each code connects a register of the right length and makes the right capture. A single serial stream cannot tell a register's contents apart from its length. The bench therefore loads each code in turn. It then shifts a lone marker bit through a data scan longer than the longest register. It expects the captured word first and the marker at exactly the register's length. This is done on two instances with different organisations, so the 89-bit and 138-bit lengths are both proven. Reset by TMS alone is reached by loading the high-impedance code first and then holding TMS high for five edges.

// File: rtl/scan_pkg.sv
package scan_pkg;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAUSE_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAUSE_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {SEL_BYP, SEL_ID, SEL_BSR} dr_sel_e;

    localparam int IR_W = 3;
    localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
    localparam logic [IR_W-1:0] OP_IDCODE  = 3'b001;
    localparam logic [IR_W-1:0] OP_SAMPLEZ = 3'b010;
    localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

    function automatic int bsr_len(int org);
        return (org == 2) ? 138 : 89;
    endfunction

    function automatic logic [5:0] width_code(int org);
        case (org)
            0:       return 6'b100111;
            1:       return 6'b010111;
            default: return 6'b110111;
        endcase
    endfunction

    function automatic logic [31:0] id_word(int org);
        return {3'b000, 5'b01011, 6'b000000, width_code(org), 11'b00000110100, 1'b1};
    endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm import scan_pkg::*; (
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state_q
);
    tap_state_e state_d;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_RESET:    state_d = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:     state_d = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR:   state_d = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR:   state_d = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:    state_d = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR:   state_d = tms ? ST_UPD_DR : ST_PAUSE_DR;
            ST_PAUSE_DR: state_d = tms ? ST_EX2_DR : ST_PAUSE_DR;
            ST_EX2_DR:   state_d = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR:   state_d = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR:   state_d = tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR:   state_d = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:    state_d = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR:   state_d = tms ? ST_UPD_IR : ST_PAUSE_IR;
            ST_PAUSE_IR: state_d = tms ? ST_EX2_IR : ST_PAUSE_IR;
            ST_EX2_IR:   state_d = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR:   state_d = tms ? ST_SEL_DR : ST_IDLE;
            default:     state_d = ST_RESET;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state_q <= ST_RESET;
        else         state_q <= state_d;
    end

    // R1
    tms_reset_chk: assert property (@(posedge tck) disable iff (!trst_n)
        ($past(tms, 1) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4) && $past(tms, 5))
        |-> (state_q == ST_RESET));

endmodule

// File: rtl/scan_ir.sv
module scan_ir import scan_pkg::*; (
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tdi,
    input  tap_state_e state_q,
    output logic       ir_lsb,
    output dr_sel_e    dr_sel,
    output logic       hiz_force,
    output logic       drive_pins
);
    typedef struct packed {
        logic [IR_W-1:0] sh;
        logic [IR_W-1:0] op;
    } ir_regs_t;

    ir_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (state_q)
            ST_RESET:  r_d.op = OP_IDCODE;
            ST_CAP_IR: r_d.sh = IR_CAPTURE;
            ST_SH_IR:  r_d.sh = {tdi, r_q.sh[IR_W-1:1]};
            ST_UPD_IR: r_d.op = r_q.sh;
            default:   ;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) r_q <= '{sh: IR_CAPTURE, op: OP_IDCODE};
        else         r_q <= r_d;
    end

    always_comb begin
        dr_sel     = SEL_BYP;
        hiz_force  = 1'b0;
        drive_pins = 1'b0;
        case (r_q.op)
            OP_EXTEST:  begin dr_sel = SEL_BSR; drive_pins = 1'b1; end
            OP_IDCODE:  dr_sel = SEL_ID;
            OP_SAMPLEZ: begin dr_sel = SEL_BSR; hiz_force = 1'b1; end
            default:    dr_sel = SEL_BYP;
        endcase
    end

    assign ir_lsb = r_q.sh[0];

    // R2
    ir_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state_q == ST_CAP_IR) |=> (r_q.sh == IR_CAPTURE));

    // R1
    ir_reset_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state_q == ST_RESET) |=> (r_q.op == OP_IDCODE && !hiz_force));

endmodule

// File: rtl/scan_dr.sv
module scan_dr import scan_pkg::*; #(
    parameter  int ORG     = 0,
    localparam int BSR_LEN = bsr_len(ORG)
) (
    input  logic               tck,
    input  logic               trst_n,
    input  logic               tdi,
    input  tap_state_e         state_q,
    input  dr_sel_e            dr_sel,
    input  logic [BSR_LEN-1:0] pin_in,
    output logic               dr_lsb,
    output logic [BSR_LEN-1:0] pin_out
);
    localparam logic [31:0] ID_VAL = id_word(ORG);

    typedef struct packed {
        logic               byp;
        logic [31:0]        id;
        logic [BSR_LEN-1:0] bsr;
        logic [BSR_LEN-1:0] upd;
    } dr_regs_t;

    dr_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (state_q)
            ST_CAP_DR: begin
                case (dr_sel)
                    SEL_ID:  r_d.id  = ID_VAL;
                    SEL_BSR: r_d.bsr = pin_in;
                    default: r_d.byp = 1'b0;
                endcase
            end
            ST_SH_DR: begin
                case (dr_sel)
                    SEL_ID:  r_d.id  = {tdi, r_q.id[31:1]};
                    SEL_BSR: r_d.bsr = {tdi, r_q.bsr[BSR_LEN-1:1]};
                    default: r_d.byp = tdi;
                endcase
            end
            ST_UPD_DR: if (dr_sel == SEL_BSR) r_d.upd = r_q.bsr;
            default: ;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) r_q <= '{byp: 1'b0, id: ID_VAL, bsr: '0, upd: '0};
        else         r_q <= r_d;
    end

    always_comb begin
        case (dr_sel)
            SEL_ID:  dr_lsb = r_q.id[0];
            SEL_BSR: dr_lsb = r_q.bsr[0];
            default: dr_lsb = r_q.byp;
        endcase
    end

    assign pin_out = r_q.upd;

    // R6
    byp_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state_q == ST_CAP_DR && dr_sel == SEL_BYP) |=> !r_q.byp);

    // R3
    id_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state_q == ST_CAP_DR && dr_sel == SEL_ID) |=> (r_q.id == ID_VAL));

    // R10
    upd_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
        !(state_q == ST_UPD_DR && dr_sel == SEL_BSR) |=> $stable(pin_out));

endmodule

// File: rtl/scan_port.sv
module scan_port import scan_pkg::*; #(
    parameter  int ORG     = 0,
    localparam int BSR_LEN = bsr_len(ORG)
) (
    input  logic               tck,
    input  logic               trst_n,
    input  logic               tms,
    input  logic               tdi,
    output logic               tdo,
    output logic               tdo_en,
    input  logic [BSR_LEN-1:0] pin_in,
    output logic [BSR_LEN-1:0] pin_out,
    output logic               drive_pins,
    output logic               hiz_force
);
    typedef struct packed {
        logic tdo;
        logic en;
    } out_regs_t;

    tap_state_e state_q;
    dr_sel_e    dr_sel;
    logic       ir_lsb;
    logic       dr_lsb;
    out_regs_t  out_d, out_q;

    tap_fsm i_fsm (
        .tck     (tck),
        .trst_n  (trst_n),
        .tms     (tms),
        .state_q (state_q)
    );

    scan_ir i_ir (
        .tck        (tck),
        .trst_n     (trst_n),
        .tdi        (tdi),
        .state_q    (state_q),
        .ir_lsb     (ir_lsb),
        .dr_sel     (dr_sel),
        .hiz_force  (hiz_force),
        .drive_pins (drive_pins)
    );

    scan_dr #(.ORG(ORG)) i_dr (
        .tck     (tck),
        .trst_n  (trst_n),
        .tdi     (tdi),
        .state_q (state_q),
        .dr_sel  (dr_sel),
        .pin_in  (pin_in),
        .dr_lsb  (dr_lsb),
        .pin_out (pin_out)
    );

    always_comb begin
        out_d    = out_q;
        out_d.en = (state_q == ST_SH_DR) || (state_q == ST_SH_IR);
        if (out_d.en) out_d.tdo = (state_q == ST_SH_IR) ? ir_lsb : dr_lsb;
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) out_q <= '0;
        else         out_q <= out_d;
    end

    assign tdo    = out_q.tdo;
    assign tdo_en = out_q.en;

    // R8
    tdo_en_chk: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_en == ((state_q == ST_SH_DR) || (state_q == ST_SH_IR)));

endmodule

// File: tb/test_scan_port.sv
module test_scan_port;
    localparam int TCK_PERIOD = 20;
    localparam int BL1  = 89;
    localparam int BL2  = 138;
    localparam int MAXB = 160;
    localparam int NSCAN = BL2 + 2;
    localparam logic [31:0] ID1 = {3'b000, 5'b01011, 6'b000000, 6'b100111, 11'b00000110100, 1'b1};
    localparam logic [31:0] ID2 = {3'b000, 5'b01011, 6'b000000, 6'b110111, 11'b00000110100, 1'b1};
    // row: {code[2:0], hiz, drive, sel[1:0]} with sel 0 bypass, 1 id, 2 boundary
    localparam logic [6:0] VEC [8] = '{
        {3'b000, 1'b0, 1'b1, 2'd2},
        {3'b001, 1'b0, 1'b0, 2'd1},
        {3'b010, 1'b1, 1'b0, 2'd2},
        {3'b011, 1'b0, 1'b0, 2'd0},
        {3'b100, 1'b0, 1'b0, 2'd0},
        {3'b101, 1'b0, 1'b0, 2'd0},
        {3'b110, 1'b0, 1'b0, 2'd0},
        {3'b111, 1'b0, 1'b0, 2'd0}
    };

    logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
    logic [BL1-1:0] pin_in1 = '0;
    logic [BL2-1:0] pin_in2 = '0;
    logic [BL1-1:0] pin_out1;
    logic [BL2-1:0] pin_out2;
    logic tdo1, tdo2, en1, en2, drv1, drv2, hiz1, hiz2;
    logic [MAXB-1:0] dout1, dout2;
    int checks = 0, errors = 0, en_bad = 0;

    always #(TCK_PERIOD/2) tck = ~tck;

    scan_port #(.ORG(0)) i_scan_port (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo1), .tdo_en(en1),
        .pin_in(pin_in1), .pin_out(pin_out1), .drive_pins(drv1), .hiz_force(hiz1));

    scan_port #(.ORG(2)) i_scan_port_wide (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo2), .tdo_en(en2),
        .pin_in(pin_in2), .pin_out(pin_out2), .drive_pins(drv2), .hiz_force(hiz2));

    task automatic check(input string tag, input logic [MAXB-1:0] act, input logic [MAXB-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // called at negedge+1; samples just before the next rising edge
    task automatic step(input logic m, input logic d, output logic o1, output logic o2, output logic e);
        tms = m; tdi = d;
        #(TCK_PERIOD/2 - 2);
        o1 = tdo1; o2 = tdo2; e = en1;
        @(negedge tck); #1;
    endtask

    task automatic dr_scan(input int n, input logic [MAXB-1:0] din);
        logic o1, o2, e;
        dout1 = '0; dout2 = '0;
        step(1'b1, 1'b0, o1, o2, e); if (e) en_bad++;
        step(1'b0, 1'b0, o1, o2, e); if (e) en_bad++;
        step(1'b0, 1'b0, o1, o2, e); if (e) en_bad++;
        for (int i = 0; i < n; i++) begin
            step(i == n-1, din[i], o1, o2, e);
            dout1[i] = o1; dout2[i] = o2;
            if (!e) en_bad++;
        end
        step(1'b1, 1'b0, o1, o2, e); if (e) en_bad++;
        step(1'b0, 1'b0, o1, o2, e); if (e) en_bad++;
    endtask

    task automatic ir_scan(input logic [2:0] code, output logic [2:0] cap);
        logic o1, o2, e;
        step(1'b1, 1'b0, o1, o2, e);
        step(1'b1, 1'b0, o1, o2, e);
        step(1'b0, 1'b0, o1, o2, e);
        step(1'b0, 1'b0, o1, o2, e); if (e) en_bad++;
        for (int i = 0; i < 3; i++) begin
            step(i == 2, code[i], o1, o2, e);
            cap[i] = o1;
            if (!e) en_bad++;
        end
        step(1'b1, 1'b0, o1, o2, e);
        step(1'b0, 1'b0, o1, o2, e);
    endtask

    function automatic logic [MAXB-1:0] stream(input int sel, input logic [MAXB-1:0] cap, input int blen);
        int len;
        logic [MAXB-1:0] s;
        len = (sel == 0) ? 1 : (sel == 1) ? 32 : blen;
        s = '0;
        for (int i = 0; i < len; i++) s[i] = cap[i];
        s[len] = 1'b1;
        return s;
    endfunction

    initial begin
        #(TCK_PERIOD * 100000);
        checks++; errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [2:0] cap, op;
        logic [MAXB-1:0] cap1, cap2, q;
        logic o1, o2, e;
        int sel;
        string tag;

        for (int i = 0; i < BL1; i++) pin_in1[i] = ((i % 3) == 0) ^ ((i % 7) == 1);
        repeat (3) @(negedge tck);
        #1;
        // R1 reset state
        check("R1", {hiz1, drv1, en1}, 3'b000);
        check("R10", pin_out1, '0);
        trst_n = 1'b1;
        step(1'b0, 1'b0, o1, o2, e);
        // R3 and R9 identification words after reset
        dr_scan(32, '0);
        check("R3", dout1[31:0], ID1);
        check("R9", dout2[31:0], ID2);
        // R2 capture pattern
        ir_scan(3'b001, cap);
        check("R2", cap, 3'b001);

        // table: each code, length and capture through a marker scan
        for (int r = 0; r < 8; r++) begin
            op  = VEC[r][6:4];
            sel = int'(VEC[r][1:0]);
            tag = (sel == 0) ? "R6" : (sel == 1) ? "R3" : (op == 3'b000) ? "R4" : "R5";
            ir_scan(op, cap);
            check(tag, hiz1, VEC[r][3]);
            check("R4", drv1, VEC[r][2]);
            dr_scan(NSCAN, 1);
            cap1 = (sel == 1) ? MAXB'(ID1) : (sel == 2) ? MAXB'(pin_in1) : '0;
            cap2 = (sel == 1) ? MAXB'(ID2) : '0;
            check(tag, dout1, stream(sel, cap1, BL1));
            check("R9", dout2, stream(sel, cap2, BL2));
        end

        // R4 update drives pin_out; R10 other codes leave it alone
        q = '0;
        for (int i = 0; i < BL1; i++) q[i] = ((i % 5) == 2);
        ir_scan(3'b000, cap);
        dr_scan(BL1, q);
        check("R4", pin_out1, q[BL1-1:0]);
        ir_scan(3'b001, cap);
        dr_scan(32, '1);
        check("R10", pin_out1, q[BL1-1:0]);
        ir_scan(3'b011, cap);
        dr_scan(4, '1);
        check("R10", pin_out1, q[BL1-1:0]);

        // R7 TDO moves on the falling edge only (bypass)
        ir_scan(3'b111, cap);
        step(1'b1, 1'b0, o1, o2, e);
        step(1'b0, 1'b0, o1, o2, e);
        step(1'b0, 1'b0, o1, o2, e);
        tms = 1'b0; tdi = 1'b1;
        @(posedge tck); #1;
        check("R7", tdo1, 1'b0);
        @(negedge tck); #1;
        check("R7", tdo1, 1'b1);
        step(1'b1, 1'b0, o1, o2, e);
        step(1'b1, 1'b0, o1, o2, e);
        step(1'b0, 1'b0, o1, o2, e);

        // R1 five TMS-high edges clear the high-impedance force
        ir_scan(3'b010, cap);
        check("R5", hiz1, 1'b1);
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, o1, o2, e);
        check("R1", {hiz1, drv1}, 2'b00);
        step(1'b0, 1'b0, o1, o2, e);
        dr_scan(32, '0);
        check("R1", dout1[31:0], ID1);

        // R1 asynchronous reset
        ir_scan(3'b010, cap);
        check("R5", hiz1, 1'b1);
        #3 trst_n = 1'b0;
        #1;
        check("R1", hiz1, 1'b0);
        @(negedge tck); #1;
        trst_n = 1'b1;
        step(1'b0, 1'b0, o1, o2, e);
        dr_scan(32, '0);
        check("R1", dout1[31:0], ID1);

        // R8 enable only in shift states
        check("R8", en_bad, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule